// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Sequencer

This block sequences instructions for a small 8-bit core whose program store is separate from its data store. Each program word is 16 bits wide and holds one whole instruction. The block keeps the program counter and a one-word prefetch register, and it reads one word per cycle from a combinational program-memory read port. The word fetched in one cycle is the instruction executed in the next, so fetch and execute overlap and an ordinary instruction costs one cycle.

The execute side reads the current instruction, its address and a valid flag. It answers with three control-transfer requests: relative call, relative jump and return, plus an 11-bit signed word offset. When a request is taken, the word already fetched is discarded and the execute stage is shown a no-operation for one cycle. The target is fetched in that same cycle, so every taken change of flow costs two cycles.

A return-address stack of configurable depth holds the link addresses of nested calls. It reports pushes that find it full and pops that find it empty. A stall input freezes the whole sequencer.

Top module: `fx_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, the fetch address is 0, the valid flag is 0 and the instruction output is 16'h0000, the no-operation word.
- R2: The word stored at address 0 is presented as a valid instruction with address 0 in the second cycle after reset.
- R3: With no request and no stall, the word read at the fetch address in one cycle becomes the valid instruction in the next cycle, with that address, and the fetch address advances by one, wrapping modulo 2^PC_W.
- R4: A taken call moves the fetch address to (instruction address + 1 + sign-extended offset) mod 2^PC_W. It pushes instruction address + 1 onto the stack, and the next cycle is a no-operation slot.
- R5: A taken return moves the fetch address to the most recent stack entry and removes that entry, and the next cycle is a no-operation slot.
- R6: A taken jump moves the fetch address exactly as a call does, leaves the stack unchanged, and the next cycle is a no-operation slot.
- R7: In a no-operation slot the valid flag is 0, the instruction is 16'h0000 and all three request inputs are ignored, so the following cycle always executes a valid instruction.
- R8: A call taken while the stack holds STK_DEPTH entries raises the overflow flag in that cycle. The call is still taken, but no entry is stored, so the stack contents are unchanged.
- R9: A return taken while the stack is empty raises the underflow flag in that cycle and moves the fetch address to 0.
- R10: While the stall input is high, the fetch address, instruction, address, valid flag and prefetched word all hold. Requests are neither taken nor flagged, and they are acted on in the first cycle without stall.
- R11: When several requests are raised together, call wins over return and return wins over jump. Only the winner changes the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze the sequencer this cycle |
| imem_addr_o | output | PC_W | Program-memory fetch address |
| imem_rdata_i | input | IW | Program word at imem_addr_o, same cycle |
| ex_instr_o | output | IW | Instruction executing this cycle |
| ex_pc_o | output | PC_W | Address of the executing instruction |
| ex_valid_o | output | 1 | 1 for a real instruction, 0 for a no-operation slot |
| ctl_call_i | input | 1 | Execute side requests a relative call |
| ctl_ret_i | input | 1 | Execute side requests a return |
| ctl_jump_i | input | 1 | Execute side requests a relative jump |
| ctl_ofs_i | input | OFS_W | Signed word offset for call and jump |
| stk_ovf_o | output | 1 | Call taken with a full stack (this cycle) |
| stk_unf_o | output | 1 | Return taken with an empty stack (this cycle) |

## Verification
The bench builds the block with PC_W = 8 and STK_DEPTH = 4, while the offset stays at 11 bits. An 8-bit counter lets a negative offset wrap below zero and lets straight-line code roll over from 255 to 0 within a short program. Because the offset is wider than the counter, the truncating arithmetic is exercised. A four-entry stack reaches overflow after four nested calls, and a fifth return into the now-empty stack reaches underflow, all in one looping program. Random stalls and randomly forced requests, including requests raised in no-operation slots and raised together, cover the hold, ignore and priority rules.

// File: rtl/fx_seq_pkg.sv
package fx_seq_pkg;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_CALL = 2'd1,
    FLOW_RET  = 2'd2,
    FLOW_JUMP = 2'd3
  } flow_e;

endpackage

// File: rtl/fx_flow_arbiter.sv
module fx_flow_arbiter
  import fx_seq_pkg::*;
(
  input  logic  slot_valid,
  input  logic  hold,
  input  logic  req_call,
  input  logic  req_ret,
  input  logic  req_jump,
  output flow_e flow_sel,
  output logic  take
);

  logic live;
  assign live = slot_valid && !hold;

  // priority: call, then return, then jump (R11); bubbles and stalls ignore all (R7, R10)
  always_comb begin
    flow_sel = FLOW_SEQ;
    if (live) begin
      if (req_call)      flow_sel = FLOW_CALL;
      else if (req_ret)  flow_sel = FLOW_RET;
      else if (req_jump) flow_sel = FLOW_JUMP;
    end
  end

  assign take = (flow_sel != FLOW_SEQ);

endmodule

// File: rtl/fx_ret_stack.sv
module fx_ret_stack #(
  parameter int AW    = 12,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          ovf,
  output logic          unf
);

  localparam int CW   = $clog2(DEPTH + 1);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0]   fill;
  logic [AW-1:0]   slot_q [DEPTH];
  logic            full, empty, push_ok, pop_ok;
  logic [IDXW-1:0] top_idx;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign ovf     = push && full;
  assign unf     = pop && empty;
  assign top_idx = IDXW'(fill - CW'(1));
  assign top_data = empty ? '0 : slot_q[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)       fill <= '0;
    else if (push_ok) fill <= fill + CW'(1);
    else if (pop_ok)  fill <= fill - CW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                            slot_q[i] <= '0;
      else if (push_ok && fill == CW'(i))    slot_q[i] <= push_data;
    end
  end

endmodule

// File: rtl/fx_target_calc.sv
module fx_target_calc
  import fx_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int OW = 11
) (
  input  logic [AW-1:0] fetch_pc,
  input  logic [AW-1:0] exec_pc,
  input  logic [OW-1:0] rel_ofs,
  input  logic [AW-1:0] ret_addr,
  input  flow_e         flow_sel,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] link_addr
);

  localparam int SW = AW + OW;

  function automatic logic [AW-1:0] inc_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] rel_target(input logic [AW-1:0] base,
                                               input logic [OW-1:0] ofs);
    logic [SW-1:0] s_ext, b_ext;
    s_ext = {{AW{ofs[OW-1]}}, ofs};
    b_ext = {{OW{1'b0}}, base};
    return AW'(b_ext + s_ext + SW'(1));
  endfunction

  assign link_addr = inc_addr(exec_pc);

  always_comb begin
    unique case (flow_sel)
      FLOW_CALL, FLOW_JUMP: next_pc = rel_target(exec_pc, rel_ofs);
      FLOW_RET:             next_pc = ret_addr;
      default:              next_pc = inc_addr(fetch_pc);
    endcase
  end

endmodule

// File: rtl/fx_prefetch.sv
module fx_prefetch #(
  parameter int AW = 12,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          flush,
  input  logic [IW-1:0] fetch_word,
  input  logic [AW-1:0] fetch_pc,
  output logic [IW-1:0] ir,
  output logic [AW-1:0] ir_pc,
  output logic          ir_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir       <= '0;
      ir_pc    <= '0;
      ir_valid <= 1'b0;
    end else if (!hold) begin
      ir_pc <= fetch_pc;
      if (flush) begin
        ir       <= '0;
        ir_valid <= 1'b0;
      end else begin
        ir       <= fetch_word;
        ir_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
  import fx_seq_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int IW        = 16,
  parameter int OFS_W     = 11,
  parameter int STK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  output logic [PC_W-1:0]  imem_addr_o,
  input  logic [IW-1:0]    imem_rdata_i,
  output logic [IW-1:0]    ex_instr_o,
  output logic [PC_W-1:0]  ex_pc_o,
  output logic             ex_valid_o,
  input  logic             ctl_call_i,
  input  logic             ctl_ret_i,
  input  logic             ctl_jump_i,
  input  logic [OFS_W-1:0] ctl_ofs_i,
  output logic             stk_ovf_o,
  output logic             stk_unf_o
);

  logic [PC_W-1:0] pc_q, next_pc, link_addr, ret_addr;
  flow_e           flow_sel;
  logic            redirect_take;
  logic            push_req, pop_req;

  fx_flow_arbiter u_arb (
    .slot_valid (ex_valid_o),
    .hold       (stall_i),
    .req_call   (ctl_call_i),
    .req_ret    (ctl_ret_i),
    .req_jump   (ctl_jump_i),
    .flow_sel   (flow_sel),
    .take       (redirect_take)
  );

  assign push_req = (flow_sel == FLOW_CALL);
  assign pop_req  = (flow_sel == FLOW_RET);

  fx_ret_stack #(.AW(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_req),
    .pop       (pop_req),
    .push_data (link_addr),
    .top_data  (ret_addr),
    .ovf       (stk_ovf_o),
    .unf       (stk_unf_o)
  );

  fx_target_calc #(.AW(PC_W), .OW(OFS_W)) u_calc (
    .fetch_pc  (pc_q),
    .exec_pc   (ex_pc_o),
    .rel_ofs   (ctl_ofs_i),
    .ret_addr  (ret_addr),
    .flow_sel  (flow_sel),
    .next_pc   (next_pc),
    .link_addr (link_addr)
  );

  fx_prefetch #(.AW(PC_W), .IW(IW)) u_pf (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (stall_i),
    .flush      (redirect_take),
    .fetch_word (imem_rdata_i),
    .fetch_pc   (pc_q),
    .ir         (ex_instr_o),
    .ir_pc      (ex_pc_o),
    .ir_valid   (ex_valid_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_q <= '0;
    else if (!stall_i) pc_q <= next_pc;
  end

  assign imem_addr_o = pc_q;

endmodule

// File: rtl/fx_sequencer_chk.sv
module fx_sequencer_chk #(
  parameter int PC_W  = 12,
  parameter int IW    = 16,
  parameter int OFS_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_i,
  input logic [PC_W-1:0]  imem_addr_o,
  input logic [IW-1:0]    ex_instr_o,
  input logic [PC_W-1:0]  ex_pc_o,
  input logic             ex_valid_o,
  input logic             ctl_call_i,
  input logic             ctl_ret_i,
  input logic             ctl_jump_i,
  input logic [OFS_W-1:0] ctl_ofs_i,
  input logic             stk_ovf_o,
  input logic             stk_unf_o,
  input logic             redirect_take
);

  function automatic logic [PC_W-1:0] hop(input logic [PC_W-1:0] at,
                                          input logic [OFS_W-1:0] o);
    logic signed [31:0] d;
    d = 32'(signed'(o));
    return PC_W'(32'(at) + 32'd1 + d);
  endfunction

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !redirect_take) |=> (ex_valid_o && ex_pc_o == $past(imem_addr_o))); // R3

  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_take && ctl_call_i) |=> (imem_addr_o == hop($past(ex_pc_o), $past(ctl_ofs_i)))); // R4

  AST_FLUSH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_take |=> (!ex_valid_o && ex_instr_o == '0)); // R7

  AST_BUBBLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_valid_o && !stall_i) |=> ex_valid_o); // R7

  AST_OVF_ON_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf_o |-> (ctl_call_i && ex_valid_o && !stall_i)); // R8

  AST_UNF_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf_o |-> (ctl_ret_i && !ctl_call_i && ex_valid_o && !stall_i)); // R9

  AST_UNF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf_o |=> (imem_addr_o == '0)); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(imem_addr_o) && $stable(ex_instr_o) && $stable(ex_valid_o))); // R10

  AST_STALL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !(stk_ovf_o || stk_unf_o || redirect_take)); // R10

endmodule

bind fx_sequencer fx_sequencer_chk #(.PC_W(PC_W), .IW(IW), .OFS_W(OFS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall_i       (stall_i),
  .imem_addr_o   (imem_addr_o),
  .ex_instr_o    (ex_instr_o),
  .ex_pc_o       (ex_pc_o),
  .ex_valid_o    (ex_valid_o),
  .ctl_call_i    (ctl_call_i),
  .ctl_ret_i     (ctl_ret_i),
  .ctl_jump_i    (ctl_jump_i),
  .ctl_ofs_i     (ctl_ofs_i),
  .stk_ovf_o     (stk_ovf_o),
  .stk_unf_o     (stk_unf_o),
  .redirect_take (redirect_take)
);

// File: tb/fx_sequencer_bench.sv
`timescale 1ns/1ps
module fx_sequencer_bench;
  localparam int PC_W  = 8;
  localparam int IW    = 16;
  localparam int OFS_W = 11;
  localparam int DEPTH = 4;
  localparam int MEMN  = 1 << PC_W;
  localparam int MASK  = MEMN - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, stall;
  logic [PC_W-1:0]  imem_addr, ex_pc;
  logic [IW-1:0]    imem_rdata, ex_instr;
  logic             ex_valid, c_call, c_ret, c_jump, ovf, unf;
  logic [OFS_W-1:0] c_ofs;
  logic             f_call, f_ret, f_jump;
  logic [OFS_W-1:0] f_ofs;
  logic [IW-1:0]    mem [MEMN];

  assign imem_rdata = mem[imem_addr];
  // execute stub: [15:12]=C call, =D jump, word 16'h0012 return, [10:0] offset
  assign c_call = f_call | (ex_instr[15:12] == 4'hC);
  assign c_jump = f_jump | (ex_instr[15:12] == 4'hD);
  assign c_ret  = f_ret  | (ex_instr == 16'h0012);
  assign c_ofs  = (f_call | f_jump) ? f_ofs : ex_instr[10:0];

  fx_sequencer #(.PC_W(PC_W), .IW(IW), .OFS_W(OFS_W), .STK_DEPTH(DEPTH)) u_fx_sequencer (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .imem_addr_o(imem_addr),
    .imem_rdata_i(imem_rdata), .ex_instr_o(ex_instr), .ex_pc_o(ex_pc),
    .ex_valid_o(ex_valid), .ctl_call_i(c_call), .ctl_ret_i(c_ret),
    .ctl_jump_i(c_jump), .ctl_ofs_i(c_ofs), .stk_ovf_o(ovf), .stk_unf_o(unf)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_pc, m_irpc;
  logic [IW-1:0] m_ir;
  bit m_valid;
  int stk[$];
  string m_tag;
  int seen_ovf = 0, seen_unf = 0, seen_prio = 0, seen_bubble_force = 0, seen_stall_req = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(bit st, bit fc, bit fr, bit fj, logic [OFS_W-1:0] fo);
    bit dc, dr, dj, eovf, eunf;
    int o, tgt;
    stall = st; f_call = fc; f_ret = fr; f_jump = fj; f_ofs = fo;
    #1;
    chk(imem_addr == m_pc[PC_W-1:0], m_tag, "fetch address", int'(imem_addr), m_pc);
    chk(ex_valid == m_valid, m_valid ? m_tag : "R7", "valid flag", int'(ex_valid), int'(m_valid));
    chk(ex_instr == m_ir, m_valid ? m_tag : "R7", "instruction", int'(ex_instr), int'(m_ir));
    if (m_valid) chk(ex_pc == m_irpc[PC_W-1:0], m_tag, "instruction address", int'(ex_pc), m_irpc);
    dc = fc | (m_ir[15:12] == 4'hC);
    dj = fj | (m_ir[15:12] == 4'hD);
    dr = fr | (m_ir == 16'h0012);
    o = (fc | fj) ? int'(fo) : int'(m_ir[10:0]);
    if (o >= 1024) o -= 2048;
    eovf = 1'b0; eunf = 1'b0;
    if (!m_valid && (dc || dr || dj) && !st) seen_bubble_force++;
    if (st) begin
      if (m_valid && (dc || dr || dj)) seen_stall_req++;
      m_tag = "R10";
    end else if (m_valid && (dc || dr || dj)) begin
      if (dc) begin
        if (stk.size() < DEPTH) stk.push_back((m_irpc + 1) & MASK);
        else eovf = 1'b1;
        tgt = (m_irpc + 1 + o) & MASK;
        m_tag = (dr || dj) ? "R11" : "R4";
      end else if (dr) begin
        if (stk.size() > 0) tgt = stk.pop_back();
        else begin tgt = 0; eunf = 1'b1; end
        m_tag = dj ? "R11" : "R5";
      end else begin
        tgt = (m_irpc + 1 + o) & MASK;
        m_tag = "R6";
      end
      if (m_tag == "R11") seen_prio++;
      m_pc = tgt; m_ir = '0; m_valid = 1'b0;
    end else begin
      m_ir = mem[m_pc]; m_irpc = m_pc; m_valid = 1'b1;
      m_pc = (m_pc + 1) & MASK; m_tag = "R3";
    end
    chk(ovf == eovf, "R8", "overflow flag", int'(ovf), int'(eovf));
    chk(unf == eunf, "R9", "underflow flag", int'(unf), int'(eunf));
    if (eovf) seen_ovf++;
    if (eunf) seen_unf++;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MEMN; i++) mem[i] = 16'h1000 | 16'(i);
    mem[3]   = 16'hC00A;               // call +10 -> 14
    mem[15]  = 16'h0012;               // return
    mem[6]   = 16'hD7F0;               // jump -16 -> 247 (wraps)
    mem[250] = 16'hD019;               // jump +25 -> 20 (wraps)
    for (int k = 0; k < 5; k++) begin
      mem[20 + 2 * k] = 16'hC001;      // nested calls, fifth overflows
      mem[21 + 2 * k] = 16'h0012;
    end
    mem[29] = 16'h0012;
    mem[30] = 16'h0012;
    rst_n = 1'b0; stall = 1'b0; f_call = 0; f_ret = 0; f_jump = 0; f_ofs = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(imem_addr == '0 && ex_valid == 1'b0 && ex_instr == '0, "R1", "state in reset",
        int'(ex_instr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = 0; m_irpc = 0; m_ir = '0; m_valid = 1'b0; m_tag = "R1";
    #1;
    chk(imem_addr == '0 && ex_valid == 1'b0 && ex_instr == '0, "R1", "first cycle after reset",
        int'(imem_addr), 0);
    cycle(0, 0, 0, 0, '0);
    chk(ex_valid == 1'b1 && ex_pc == '0 && ex_instr == mem[0], "R2", "word 0 in second cycle",
        int'(ex_instr), int'(mem[0]));
    for (int n = 0; n < 160; n++) cycle(0, 0, 0, 0, '0);
    // all three raised together on a plain instruction (R11)
    while (!(m_valid && m_ir[15:12] == 4'h1)) cycle(0, 0, 0, 0, '0);
    cycle(0, 1, 1, 1, 11'd3);
    for (int n = 0; n < 400; n++) cycle(($urandom_range(0, 9) < 3), 0, 0, 0, '0);
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom_range(0, 99);
      cycle(($urandom_range(0, 9) < 2), (r < 5), (r >= 3 && r < 10), (r >= 8 && r < 14),
            OFS_W'($urandom_range(0, 2047)));
    end
    chk(seen_ovf > 0, "R8", "overflow events seen", seen_ovf, 1);
    chk(seen_unf > 0, "R9", "underflow events seen", seen_unf, 1);
    chk(seen_prio > 0, "R11", "combined requests seen", seen_prio, 1);
    chk(seen_bubble_force > 0, "R7", "requests in empty slots seen", seen_bubble_force, 1);
    chk(seen_stall_req > 0, "R10", "requests during stall seen", seen_stall_req, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule